// File: doc/BRIEF.md
# Broadcast Constant Cache Request Serializer

This block takes one warp-wide read of up to 32 lane word addresses and answers it from a small direct-mapped read-only cache. The cache array yields the data of exactly one address per access, so the block picks one address at a time. The word read for that address is written to every active lane that asked for it. When the whole warp asks for one address, a single access serves all of it. When the lanes ask for K different addresses, the request takes K accesses, and throughput drops by that factor.

Each access looks up its line. On a hit it is served in one cycle. On a miss the block raises a line fill request toward backing memory and holds it until the response arrives. It then writes the line and serves the same address as a hit. Addresses are taken in the order of the lowest-numbered lane still waiting. When the last lane is served, a one-cycle done pulse appears with the per-lane results, the number of accesses used and the number of misses taken.

Top module: `ccs_broadcast_server`

## Requirements
- R1: After reset every cache line is invalid. `req_ready` is 1, and `rsp_done` and `mem_req_valid` are 0.
- R2: A warp whose active lanes all use one address takes exactly one access, and every active lane receives that word.
- R3: `rsp_accesses` equals the number of different addresses among the active lanes.
- R4: Each active lane's 32-bit result is the backing-memory word at its own address. Word i of a fill response (bits 32*i+31:32*i) holds the word at line address * 4 + i.
- R5: Inactive lanes return 0. Their addresses cause no access and no fill.
- R6: A lookup miss raises `mem_req_valid` with `mem_req_line` = address >> 2. Both are held until `mem_rsp_valid`. Each miss adds one to `rsp_misses`, and after the fill the same address hits.
- R7: A hit needs no fill and costs one cycle. A warp of K different addresses that all hit pulses `rsp_done` K cycles after the accepting clock edge.
- R8: Different addresses are served in the order of the lowest-numbered waiting lane that uses each one, and this order is visible in the sequence of fill requests.
- R9: A request with no active lane pulses `rsp_done` in the cycle right after acceptance, with 0 accesses and 0 misses.
- R10: `req_ready` is low from acceptance until done. `rsp_done` lasts one cycle, and results stay stable until the next request is accepted.
- R11: The cache has 8 lines indexed by line address bits [2:0]. Two addresses in one warp whose lines share an index but differ in tag each miss, and a later access to the first address misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A warp request is offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_active | input | LANES | Lane active mask |
| req_addr | input | LANES*AW | Word address per lane, lane g at bits AW*g upward |
| rsp_done | output | 1 | One-cycle pulse at the end of a warp request |
| rsp_data | output | LANES*32 | Per-lane result words |
| rsp_accesses | output | $clog2(LANES+1) | Accesses used by the last request |
| rsp_misses | output | $clog2(LANES+1) | Misses taken by the last request |
| mem_req_valid | output | 1 | Line fill request to backing memory |
| mem_req_line | output | AW-2 | Line address being fetched |
| mem_rsp_valid | input | 1 | Fill data is valid |
| mem_rsp_data | input | LINE_WORDS*32 | Full line of fill data |

## Verification
The warp is driven with a single shared address, cold and then warm, which shows broadcast apart from plain hit timing. Patterns with 4 and 8 different addresses spread over one or two lines separate access counting from miss counting. A reversed-lane pattern shows the service order through the sequence of fill requests. A half-active mask with unseen addresses on the idle lanes, an empty mask, and two tags that fight for one index cover what must be ignored, the zero-length request and eviction.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int unsigned WORD_W = 32;
  typedef enum logic [1:0] {ST_IDLE, ST_SERVE, ST_FILL, ST_FINISH} ccs_state_e;
endpackage

// File: rtl/ccs_lane_pick.sv
module ccs_lane_pick #(
  parameter int LANES = 32,
  parameter int AW    = 16
) (
  input  logic [LANES-1:0]    pending,
  input  logic [LANES*AW-1:0] addr_flat,
  output logic                any,
  output logic [AW-1:0]       lead_addr,
  output logic [LANES-1:0]    match
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  // lowest-numbered set bit of the waiting mask
  function automatic logic [LW-1:0] lowest_lane(input logic [LANES-1:0] m);
    logic [LW-1:0] r;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (m[i]) r = i[LW-1:0];
    end
    return r;
  endfunction

  logic [LW-1:0] lead_lane;

  assign any       = |pending;
  assign lead_lane = lowest_lane(pending);
  assign lead_addr = addr_flat[lead_lane*AW +: AW];

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign match[g] = pending[g] && (addr_flat[g*AW +: AW] == lead_addr);
  end
endmodule

// File: rtl/ccs_line_store.sv
module ccs_line_store #(
  parameter int AW         = 16,
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 4,
  localparam int OFFW = $clog2(LINE_WORDS),
  localparam int IDXW = $clog2(LINES),
  localparam int TAGW = AW - OFFW - IDXW,
  localparam int LAW  = AW - OFFW,
  localparam int LBITS = LINE_WORDS * ccs_pkg::WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    lk_addr,
  output logic             lk_hit,
  output logic [31:0]      lk_word,
  input  logic             fill_en,
  input  logic [LAW-1:0]   fill_line,
  input  logic [LBITS-1:0] fill_data
);
  function automatic logic [IDXW-1:0] index_of(input logic [LAW-1:0] line);
    return line[IDXW-1:0];
  endfunction

  function automatic logic [TAGW-1:0] tag_of(input logic [LAW-1:0] line);
    return line[LAW-1:IDXW];
  endfunction

  logic [LINES-1:0] valid_q;
  logic [TAGW-1:0]  tag_q  [LINES];
  logic [LBITS-1:0] data_q [LINES];

  logic [LAW-1:0]  lk_line;
  logic [IDXW-1:0] lk_idx;
  logic [OFFW-1:0] lk_off;

  assign lk_line = lk_addr[AW-1:OFFW];
  assign lk_off  = lk_addr[OFFW-1:0];
  assign lk_idx  = index_of(lk_line);
  assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == tag_of(lk_line));
  assign lk_word = data_q[lk_idx][lk_off*ccs_pkg::WORD_W +: ccs_pkg::WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (fill_en) begin
      valid_q[index_of(fill_line)] <= 1'b1;
      tag_q[index_of(fill_line)]   <= tag_of(fill_line);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) data_q[index_of(fill_line)] <= fill_data;
  end
endmodule

// File: rtl/ccs_broadcast_server.sv
module ccs_broadcast_server #(
  parameter int LANES      = 32,
  parameter int AW         = 16,
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 4,
  localparam int CW    = $clog2(LANES + 1),
  localparam int OFFW  = $clog2(LINE_WORDS),
  localparam int LAW   = AW - OFFW,
  localparam int LBITS = LINE_WORDS * 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES*AW-1:0] req_addr,
  output logic                rsp_done,
  output logic [LANES*32-1:0] rsp_data,
  output logic [CW-1:0]       rsp_accesses,
  output logic [CW-1:0]       rsp_misses,
  output logic                mem_req_valid,
  output logic [LAW-1:0]      mem_req_line,
  input  logic                mem_rsp_valid,
  input  logic [LBITS-1:0]    mem_rsp_data
);
  import ccs_pkg::*;

  ccs_state_e state_q;
  logic [LANES-1:0]    pending_q;
  logic [LANES*AW-1:0] addr_q;
  logic [CW-1:0]       acc_q, miss_q;
  logic [LAW-1:0]      fill_line_q;
  logic [31:0]         res_q [LANES];

  logic                any_pending;
  logic [AW-1:0]       lead_addr;
  logic [LANES-1:0]    match;
  logic                lk_hit;
  logic [31:0]         lk_word;

  // named internal events
  logic accept_evt, serve_evt, miss_evt, fill_evt, last_evt;

  assign accept_evt = (state_q == ST_IDLE) && req_valid;
  assign serve_evt  = (state_q == ST_SERVE) && lk_hit;
  assign miss_evt   = (state_q == ST_SERVE) && !lk_hit;
  assign fill_evt   = (state_q == ST_FILL) && mem_rsp_valid;
  assign last_evt   = serve_evt && ((pending_q & ~match) == '0);

  ccs_lane_pick #(.LANES(LANES), .AW(AW)) i_pick (
    .pending   (pending_q),
    .addr_flat (addr_q),
    .any       (any_pending),
    .lead_addr (lead_addr),
    .match     (match)
  );

  ccs_line_store #(.AW(AW), .LINES(LINES), .LINE_WORDS(LINE_WORDS)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_addr   (lead_addr),
    .lk_hit    (lk_hit),
    .lk_word   (lk_word),
    .fill_en   (fill_evt),
    .fill_line (fill_line_q),
    .fill_data (mem_rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pending_q   <= '0;
      addr_q      <= '0;
      acc_q       <= '0;
      miss_q      <= '0;
      fill_line_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_evt) begin
          pending_q <= req_active;
          addr_q    <= req_addr;
          acc_q     <= '0;
          miss_q    <= '0;
          state_q   <= (req_active == '0) ? ST_FINISH : ST_SERVE;
        end
        ST_SERVE: begin
          if (!any_pending) begin
            state_q <= ST_FINISH;
          end else if (lk_hit) begin
            pending_q <= pending_q & ~match;
            acc_q     <= acc_q + 1'b1;
            if (last_evt) state_q <= ST_FINISH;
          end else begin
            miss_q      <= miss_q + 1'b1;
            fill_line_q <= lead_addr[AW-1:OFFW];
            state_q     <= ST_FILL;
          end
        end
        ST_FILL: if (mem_rsp_valid) state_q <= ST_SERVE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n || accept_evt)        res_q[g] <= '0;
      else if (serve_evt && match[g]) res_q[g] <= lk_word;
    end
    assign rsp_data[g*32 +: 32] = res_q[g];
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_done      = (state_q == ST_FINISH);
  assign rsp_accesses  = acc_q;
  assign rsp_misses    = miss_q;
  assign mem_req_valid = (state_q == ST_FILL);
  assign mem_req_line  = fill_line_q;

  p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_fill_from_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(miss_evt));
  p_fill_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_rsp_valid |=> mem_req_valid && $stable(mem_req_line));
  p_hit_after_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> lk_hit);
  p_serve_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
    serve_evt |=> $countones(pending_q) < $past($countones(pending_q)));
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> rsp_accesses <= CW'(LANES));
endmodule

// File: tb/test_ccs_broadcast_server.sv
module test_ccs_broadcast_server;
  localparam int LANES = 32;
  localparam int AW    = 16;
  localparam int CW    = $clog2(LANES + 1);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [LANES-1:0]    req_active = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic                rsp_done;
  logic [LANES*32-1:0] rsp_data;
  logic [CW-1:0]       rsp_accesses, rsp_misses;
  logic                mem_req_valid;
  logic [AW-3:0]       mem_req_line;
  logic                mem_rsp_valid = 1'b0;
  logic [127:0]        mem_rsp_data = '0;

  int total = 0, bad = 0;
  int fill_cnt = 0;
  logic [AW-3:0] fill_log [16];
  logic [AW-1:0] adr [LANES];
  int got_n, got_acc, got_miss, got_fills;

  always #5 clk = ~clk;

  ccs_broadcast_server i_ccs_broadcast_server (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .rsp_accesses(rsp_accesses), .rsp_misses(rsp_misses),
    .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] word_at(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // backing memory: answers each fill two cycles after seeing it
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid && !mem_rsp_valid) begin
        if (fill_cnt < 16) fill_log[fill_cnt] = mem_req_line;
        fill_cnt++;
        repeat (2) @(negedge clk);
        for (int w = 0; w < 4; w++)
          mem_rsp_data[w*32 +: 32] = word_at({mem_req_line, 2'(w)});
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic run_warp(input string tag);
    int f0, n, first_bad;
    logic [31:0] exp_w, got_w, snap;
    f0 = fill_cnt;
    @(negedge clk);
    for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = adr[l];
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, {"R10 busy ", tag}, req_ready, 0);
    n = 0;
    while (!rsp_done) begin
      n++;
      @(negedge clk);
    end
    got_n = n; got_acc = rsp_accesses; got_miss = rsp_misses;
    got_fills = fill_cnt - f0;
    first_bad = -1; exp_w = '0; got_w = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [31:0] e;
      e = req_active[l] ? word_at(adr[l]) : 32'h0;
      if (rsp_data[l*32 +: 32] !== e && first_bad < 0) begin
        first_bad = l; exp_w = e; got_w = rsp_data[l*32 +: 32];
      end
    end
    check(first_bad < 0, {"R4/R5 lane data ", tag}, got_w, exp_w);
    snap = rsp_data[31:0];
    @(negedge clk);
    check(rsp_done == 1'b0 && rsp_data[31:0] == snap, {"R10 pulse/hold ", tag}, rsp_done, 0);
  endtask

  function automatic int distinct_count();
    int c = 0;
    for (int l = 0; l < LANES; l++) begin
      bit seen = 0;
      for (int k = 0; k < l; k++)
        if (req_active[k] && adr[k] == adr[l]) seen = 1;
      if (req_active[l] && !seen) c++;
    end
    return c;
  endfunction

  task automatic t_reset;
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(rsp_done == 1'b0, "R1 done", rsp_done, 0);
    check(mem_req_valid == 1'b0, "R1 fill", mem_req_valid, 0);
  endtask

  task automatic t_broadcast;
    req_active = '1;
    for (int l = 0; l < LANES; l++) adr[l] = 16'h0105;
    run_warp("bcast cold");
    check(got_acc == 1, "R2 one access", got_acc, 1);
    check(got_miss == 1 && got_fills == 1, "R1 R6 cold miss", got_miss, 1);
    check(fill_log[0] == 14'h041, "R6 line address", fill_log[0], 14'h041);
    run_warp("bcast warm");
    check(got_miss == 0 && got_fills == 0, "R7 no fill on hit", got_fills, 0);
    check(got_n == 1, "R7 hit latency", got_n, 1);
  endtask

  task automatic t_distinct;
    req_active = '1;
    for (int l = 0; l < LANES; l++) adr[l] = 16'h0100 + 16'(l % 4);
    run_warp("four");
    check(got_acc == distinct_count(), "R3 four addresses", got_acc, distinct_count());
    check(got_miss == 1, "R6 one line", got_miss, 1);
    run_warp("four warm");
    check(got_n == 4, "R7 four hits latency", got_n, 4);
    for (int l = 0; l < LANES; l++) adr[l] = 16'h0200 + 16'(l % 8);
    run_warp("eight");
    check(got_acc == 8, "R3 eight addresses", got_acc, 8);
    check(got_miss == 2 && got_fills == 2, "R6 two lines", got_miss, 2);
  endtask

  task automatic t_order;
    int f0;
    req_active = '1;
    for (int l = 0; l < LANES; l++) adr[l] = 16'h0528;
    adr[1] = 16'h0514;
    f0 = fill_cnt;
    run_warp("order");
    check(got_acc == 2, "R3 order count", got_acc, 2);
    check(fill_log[f0] == 14'h14A, "R8 first fill", fill_log[f0], 14'h14A);
    check(fill_log[f0+1] == 14'h145, "R8 second fill", fill_log[f0+1], 14'h145);
  endtask

  task automatic t_inactive;
    for (int l = 0; l < LANES; l++) begin
      req_active[l] = l[0];
      adr[l] = l[0] ? 16'h0529 : 16'h07F0;
    end
    run_warp("odd lanes");
    check(got_acc == 1, "R5 idle lanes not counted", got_acc, 1);
    check(got_fills == 0, "R5 idle lanes no fill", got_fills, 0);
  endtask

  task automatic t_empty;
    req_active = '0;
    run_warp("empty");
    check(got_n == 0, "R9 immediate done", got_n, 0);
    check(got_acc == 0 && got_miss == 0, "R9 zero counts", got_acc, 0);
  endtask

  task automatic t_conflict;
    req_active = '1;
    for (int l = 0; l < LANES; l++) adr[l] = 16'h0800;
    adr[1] = 16'h0820;
    run_warp("conflict");
    check(got_acc == 2 && got_miss == 2, "R11 both miss", got_miss, 2);
    for (int l = 0; l < LANES; l++) adr[l] = 16'h0800;
    run_warp("evicted");
    check(got_miss == 1, "R11 evicted line refetched", got_miss, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_broadcast();
    t_distinct();
    t_order();
    t_inactive();
    t_empty();
    t_conflict();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule